// File: doc/BRIEF.md
# Two-Wire Serial Byte-Store Slave

This block is the slave side of a two-wire serial bus that fronts an internal byte array of 8192 locations. The bus master drives the clock line and produces every Start and Stop. The block watches the clock and data lines and drives data only through an open-drain enable: when `sda_oe` is high, the pad pulls SDA low. Both lines are sampled with the system clock through a synchroniser. Bit events are taken from the edges of the sampled clock.

A transfer begins with a control byte. Its upper nibble is a fixed device code, the next three bits must equal the strap inputs, and the last bit selects read or write. Up to eight copies with different strap settings can share one bus. A write supplies two address bytes and then any number of data bytes. Successive data bytes stay inside one 32-byte page. A read returns the byte at the internal address pointer and advances the pointer across the whole array. Random reads use a write header, then a repeated Start, then a read control byte. The write-lock input blocks every store to the array while still acknowledging the bytes. Reads are not affected by it.

The controller is one state machine with these states:

- `ST_IDLE`: waiting for a Start.
- `ST_CTRL` and `ST_CTRL_ACK`: the control byte and its acknowledge.
- `ST_AHI` and `ST_AHI_ACK`: the high address byte and its acknowledge.
- `ST_ALO` and `ST_ALO_ACK`: the low address byte and its acknowledge.
- `ST_WDATA` and `ST_WDATA_ACK`: a write data byte and its acknowledge.
- `ST_RDATA`: a read byte being sent.
- `ST_RACK`: the master's acknowledge after a read byte.
- `ST_SKIP`: ignoring the bus until the next Start or Stop.

Transitions:

- A Stop moves from any state to `ST_IDLE`.
- A Start moves from any state to `ST_CTRL`.
- After the eighth bit, a receive state moves to its acknowledge state on the SCL fall. The exception is `ST_CTRL` with a mismatched control byte, which moves to `ST_SKIP`.
- `ST_CTRL_ACK` moves to `ST_RDATA` for a read and to `ST_AHI` for a write.
- `ST_AHI_ACK` moves to `ST_ALO`.
- `ST_ALO_ACK` and `ST_WDATA_ACK` both move to `ST_WDATA`.
- `ST_RDATA` moves to `ST_RACK` after its eighth bit.
- `ST_RACK` moves to `ST_RDATA` when the master acknowledged and to `ST_SKIP` when it did not.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The array holds 8192 bytes addressed by a 13-bit pointer. The pointer is built from the low 5 bits of the first address byte (high part) and all 8 bits of the second. The upper 3 bits of the first address byte are ignored.
- R2: Control byte bits are sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `strap[2:0]`, and bit 0 selects read (1) or write (0). On any mismatch the block gives no acknowledge and drives nothing until the next Start or Stop.
- R3: For every accepted byte the block asserts `sda_oe` during the ninth SCL clock. Accepted bytes are the matching control byte, both address bytes and every write data byte.
- R4: A Start (SDA falls while SCL is high) or a Stop (SDA rises while SCL is high) restarts the protocol from any state. A partly received byte is discarded and never written.
- R5: A byte written to an address is returned by a later random read of that address. Data bytes are sent MSB first.
- R6: During a sequential write, the pointer's low 5 bits advance after each data byte and wrap inside the 32-byte page. The upper 8 bits of the pointer do not change.
- R7: During a read, each master acknowledge continues with the next byte. The pointer advances by one after each byte sent and wraps from 0x1FFF to 0x0000.
- R8: A current-address read, which is a read control byte with no address header, returns the byte one past the last byte read.
- R9: While `wr_lock` is high, all bytes are still acknowledged but no array location changes. Reads work normally while the lock is high.
- R10: SDA is sampled on the rising edge of SCL. `sda_oe` is only asserted after SCL has gone low.
- R11: After reset the block is idle with `sda_oe` low.
- R12: A master no-acknowledge after a read byte ends the read. The block releases SDA and drives nothing until the next Start or Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| strap | input | 3 | Bus address select straps |
| wr_lock | input | 1 | High blocks all array writes |

## Verification
On every cycle, the assertions check the protocol skeleton:
- Start and Stop force the state machine to `ST_CTRL` and `ST_IDLE`.
- The pull-down is released whenever the block is idle or skipping.
- The pull-down only turns on while the sampled clock is low.
- No array write is issued under a held write lock.
- A page write never disturbs the upper pointer bits.

Only the bench's bus scenarios can show the data behaviour: the page wrap, the full-array rollover, the current-address and random reads, strap and device-code filtering, and aborted bytes leaving memory intact.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } ee_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/ee_line_sampler.sv
module ee_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_chain;
    logic [MSB:0] sda_chain;
    logic         scl_prev;
    logic         sda_prev;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[MSB-1:0], scl_i};
                    sda_chain <= {sda_chain[MSB-1:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[MSB];
            sda_prev <= sda_chain[MSB];
        end
    end

    assign scl_lvl  = scl_chain[MSB];
    assign sda_lvl  = sda_chain[MSB];
    assign scl_rise = scl_chain[MSB] & ~scl_prev;
    assign scl_fall = ~scl_chain[MSB] & scl_prev;
    assign start_ev = scl_chain[MSB] & scl_prev & sda_prev & ~sda_chain[MSB];
    assign stop_ev  = scl_chain[MSB] & scl_prev & ~sda_prev & sda_chain[MSB];

endmodule

// File: rtl/ee_byte_array.sv
module ee_byte_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/ee_proto_fsm.sv
module ee_proto_fsm
    import ee_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_lvl,
    input  logic [2:0]        strap,
    input  logic              wr_lock,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] ptr,
    output logic [7:0]        mem_wdata,
    output ee_state_t         state
);
    localparam int HI_W = ADDR_W - BYTE_W;

    ee_state_t       state_nx;
    logic [3:0]      bit_cnt;
    logic [7:0]      rx_sr;
    logic [7:0]      tx_sr;
    logic [HI_W-1:0] hi_q;
    logic            rw_q;
    logic            mack_q;
    logic            byte_done;
    logic            ctrl_match;
    logic            rx_state;
    logic            bus_event;

    assign bus_event  = start_ev | stop_ev;
    assign byte_done  = scl_fall && (bit_cnt == 4'd8);
    assign ctrl_match = (rx_sr[7:4] == DEV_CODE) && (rx_sr[3:1] == strap);
    assign rx_state   = (state == ST_CTRL) || (state == ST_AHI) ||
                        (state == ST_ALO)  || (state == ST_WDATA);
    assign mem_we     = (state == ST_WDATA) && byte_done && !wr_lock && !bus_event;
    assign mem_wdata  = rx_sr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        if (stop_ev) begin
            state_nx = ST_IDLE;
        end else if (start_ev) begin
            state_nx = ST_CTRL;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_SKIP:      state_nx = ST_SKIP;
                ST_CTRL:      if (byte_done) state_nx = ctrl_match ? ST_CTRL_ACK : ST_SKIP;
                ST_CTRL_ACK:  if (scl_fall)  state_nx = rw_q ? ST_RDATA : ST_AHI;
                ST_AHI:       if (byte_done) state_nx = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall)  state_nx = ST_ALO;
                ST_ALO:       if (byte_done) state_nx = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall)  state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall)  state_nx = mack_q ? ST_RDATA : ST_SKIP;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            hi_q    <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (bus_event) begin
            bit_cnt <= '0;
            mack_q  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            if (scl_rise) begin
                if (rx_state && bit_cnt < 4'd8) begin
                    rx_sr   <= {rx_sr[6:0], sda_lvl};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (state == ST_RDATA && bit_cnt < 4'd8) begin
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (state == ST_RACK) begin
                    mack_q <= ~sda_lvl;
                end
            end
            if (scl_fall) begin
                case (state)
                    ST_CTRL: begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            rw_q    <= rx_sr[0];
                            sda_oe  <= ctrl_match;
                        end
                    end
                    ST_AHI: begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            hi_q    <= rx_sr[HI_W-1:0];
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_ALO: begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            ptr     <= {hi_q, rx_sr};
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            ptr     <= {ptr[ADDR_W-1:PAGE_W],
                                        PAGE_W'(ptr[PAGE_W-1:0] + PAGE_W'(1))};
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_CTRL_ACK: begin
                        if (rw_q) begin
                            tx_sr  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + ADDR_W'(1);
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: begin
                        sda_oe <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            mack_q  <= 1'b0;
                        end else begin
                            tx_sr  <= {tx_sr[6:0], 1'b0};
                            sda_oe <= ~tx_sr[6];
                        end
                    end
                    ST_RACK: begin
                        if (mack_q) begin
                            tx_sr  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + ADDR_W'(1);
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import ee_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap,
    input  logic       wr_lock
);
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_ev;
    logic              stop_ev;
    logic              mem_we;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_data;
    ee_state_t         fsm_state;

    ee_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ee_proto_fsm #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_lvl   (sda_lvl),
        .strap     (strap),
        .wr_lock   (wr_lock),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .ptr       (ptr),
        .mem_wdata (mem_wdata),
        .state     (fsm_state)
    );

    ee_byte_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (mem_wdata),
        .rdata (rd_data)
    );

endmodule

// File: rtl/ee_checks.sv
module ee_checks
    import ee_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              sda_oe,
    input logic              wr_lock,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr,
    input logic              start_ev,
    input logic              stop_ev,
    input ee_state_t         fsm_state
);

    assert_oe_on_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !sda_oe);

    assert_stop_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (fsm_state == ST_IDLE));

    assert_start_to_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (fsm_state == ST_CTRL));

    assert_lock_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && $past(wr_lock)) |-> !mem_we);

    assert_page_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R2 and R12: a skipped transfer never pulls SDA
    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SKIP) |-> !sda_oe);

endmodule

bind eeprom_i2c_slave ee_checks #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_oe    (sda_oe),
    .wr_lock   (wr_lock),
    .mem_we    (mem_we),
    .ptr       (ptr),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .fsm_state (fsm_state)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;

    localparam int Q     = 10;
    localparam int AMASK = 16'h1FFF;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       scl     = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap   = 3'b010;
    logic       wr_lock = 1'b0;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #4 clk = ~clk;

    eeprom_i2c_slave u_eeprom_i2c_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap   (strap),
        .wr_lock (wr_lock)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_byte;
    event       got_ev;
    logic [7:0] ref_mem [int];
    int         model_ptr = 0;
    int         bad_oe_rise = 0;
    logic       oe_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected read byte", got_byte, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(got_byte === e.val, e.tag, "read byte", got_byte, e.val);
            end
        end
    end

    // R10: pull-down must never turn on while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl) bad_oe_rise++;
        oe_prev <= sda_oe;
    end

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(1);
        scl = 1'b1;     wq(1);
        sda_drv = 1'b0; wq(1);
        scl = 1'b0;     wq(1);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(1);
        scl = 1'b1;     wq(1);
        sda_drv = 1'b1; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; wq(1);
            scl = 1'b1;     wq(2);
            scl = 1'b0;     wq(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_drv = 1'b1; wq(1);
        scl = 1'b1;     wq(1);
        acked = ~sda_line;
        wq(1);
        scl = 1'b0;     wq(1);
    endtask

    task automatic recv_byte(input bit master_ack);
        logic [7:0] v;
        v = '0;
        sda_drv = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(1);
            scl = 1'b1; wq(1);
            v = {v[6:0], sda_line};
            wq(1);
            scl = 1'b0;
        end
        got_byte = v;
        -> got_ev;
        sda_drv = master_ack ? 1'b0 : 1'b1;
        wq(1);
        scl = 1'b1; wq(2);
        scl = 1'b0;
        sda_drv = 1'b1;
        wq(1);
    endtask

    function automatic logic [7:0] ctrl(input logic [2:0] s, input bit rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic header(input int addr16, input string tag);
        bit a;
        send_byte(ctrl(strap, 1'b0), a);
        chk(a, "R3", {tag, " control ack"}, a, 1);
        send_byte(addr16[15:8], a);
        chk(a, "R3", {tag, " high address ack"}, a, 1);
        send_byte(addr16[7:0], a);
        chk(a, "R3", {tag, " low address ack"}, a, 1);
        model_ptr = addr16 & AMASK;
    endtask

    task automatic write_seq(input int addr16, input logic [7:0] data[$], input string tag);
        bit a;
        bus_start();
        header(addr16, tag);
        foreach (data[i]) begin
            send_byte(data[i], a);
            chk(a, "R3", {tag, " data ack"}, a, 1);
            if (!wr_lock) ref_mem[model_ptr] = data[i];
            model_ptr = (model_ptr & ~31) | ((model_ptr + 1) & 31);
        end
        bus_stop();
    endtask

    task automatic read_body(input int n, input string tag);
        bit a;
        send_byte(ctrl(strap, 1'b1), a);
        chk(a, "R3", {tag, " read control ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = ref_mem.exists(model_ptr) ? ref_mem[model_ptr] : 8'hxx;
            e.tag = tag;
            exp_q.push_back(e);
            recv_byte(i < n - 1);
            model_ptr = (model_ptr + 1) & AMASK;
        end
        wq(1);
        chk(sda_oe == 1'b0, "R12", "released after master nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic read_rand(input int addr16, input int n, input string tag);
        bus_start();
        header(addr16, tag);
        bus_start();
        read_body(n, tag);
    endtask

    task automatic read_cur(input int n, input string tag);
        bus_start();
        read_body(n, tag);
    endtask

    initial begin
        bit a;
        wq(2);
        rst_n = 1'b1;
        wq(1);
        chk(sda_oe == 1'b0, "R11", "oe after reset", sda_oe, 0);

        // R2: strap mismatch and wrong device code are not acknowledged
        bus_start();
        send_byte(ctrl(3'b011, 1'b0), a);
        chk(!a, "R2", "strap mismatch nack", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R2", "silent after mismatch", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, a);
        chk(!a, "R2", "device code mismatch nack", a, 0);
        bus_stop();

        // R5: byte writes then random read
        write_seq(16'h0123, '{8'hA5, 8'h3C}, "R5");
        read_rand(16'h0123, 1, "R5");
        // R8: current-address read continues after the last byte read
        read_cur(1, "R8");

        // R6: page wrap inside 32 bytes
        write_seq(16'h005E, '{8'h11, 8'h22, 8'h33}, "R6");
        read_rand(16'h005E, 2, "R6");
        read_rand(16'h0040, 1, "R6");

        // R7: sequential read across 0x1FFF -> 0x0000; R1: upper address bits ignored
        write_seq(16'hFFFF, '{8'h77}, "R1");
        write_seq(16'h0000, '{8'h5A}, "R7");
        read_rand(16'h1FFF, 2, "R7");
        read_rand(16'hE123, 1, "R1");

        // R9: lock blocks writes but still acks, reads still work
        wr_lock = 1'b1;
        write_seq(16'h0123, '{8'h00}, "R9");
        read_rand(16'h0123, 1, "R9");
        wr_lock = 1'b0;
        read_rand(16'h0123, 1, "R9");

        // R4: stop in the middle of a control byte, then a normal transfer
        bus_start();
        send_bits(ctrl(strap, 1'b0), 4);
        bus_stop();
        bus_start();
        send_byte(ctrl(strap, 1'b0), a);
        chk(a, "R4", "ack after aborted byte", a, 1);
        bus_stop();
        // R4: repeated start inside a data byte writes nothing
        bus_start();
        header(16'h0124, "R4");
        send_bits(8'hFF, 4);
        scl = 1'b0; wq(1);
        bus_start();
        send_byte(ctrl(strap, 1'b0), a);
        chk(a, "R4", "ack after repeated start", a, 1);
        bus_stop();
        read_rand(16'h0124, 1, "R4");

        // R2: different strap setting answers its own address
        strap = 3'b101;
        write_seq(16'h0200, '{8'hC3}, "R2");
        read_rand(16'h0200, 1, "R2");

        wq(2);
        chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        chk(bad_oe_rise == 0, "R10", "oe rose with SCL high", bad_oe_rise, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule